// File: doc/BRIEF.md
# Read-Modify-Write Operation Unit

This block carries out one read-modify-write operation on a 32-bit word in memory or in a peripheral register. A start strobe supplies a target address, a descriptor word that carries the method code, a write value and a write mask. The unit reads the word at the target address and computes a new value with the chosen method. It then writes the result back to the same address and pulses a done output. The unit decodes only the method field of the descriptor, which is 4 bits wide and starts at bit 8. All other descriptor bits are ignored.

The unit supports eleven methods. They are numbered as follows:

- 0: masked insert, `(read & ~mask) | value`
- 1: increment
- 2: decrement
- 3: logical shift right by one
- 4: logical shift left by one
- 5: rotate right by one
- 6: rotate left by one
- 7: bitwise invert
- 8: XOR with the mask
- 9: OR with the mask
- 10: AND with the mask

Codes 11 to 15 are illegal. For an illegal code the unit issues no bus traffic and ends at once with an error flag.

The sequencer has seven states:

- `S_IDLE`: waits for a start strobe.
- `S_RD_ISSUE`: raises the read request for one cycle.
- `S_RD_WAIT`: waits for read data.
- `S_CALC`: registers the computed result.
- `S_WR_ISSUE`: raises the write request for one cycle.
- `S_WR_WAIT`: waits for the write acknowledge.
- `S_DONE`: drives the done pulse.

The transitions are:

- `S_IDLE` goes to `S_RD_ISSUE` on a legal start, or to `S_DONE` on an illegal start.
- `S_RD_ISSUE` goes to `S_RD_WAIT`.
- `S_RD_WAIT` goes to `S_CALC` when read data is valid.
- `S_CALC` goes to `S_WR_ISSUE`.
- `S_WR_ISSUE` goes to `S_WR_WAIT`.
- `S_WR_WAIT` goes to `S_DONE` when the acknowledge arrives.
- `S_DONE` goes to `S_IDLE`.

Top module: `rmw_engine`

## Requirements
- R1: After reset the unit is idle, and `rd_req_o`, `wr_req_o`, `done_o` and `err_o` are all low.
- R2: A start with a legal method (0 to 10) raises `rd_req_o` for exactly one cycle, one cycle after the start edge. `rd_addr_o` carries the start address. After the read data, exactly one `wr_req_o` pulse follows two cycles after the `rd_valid_i` edge, with `wr_addr_o` equal to the same address.
- R3: Method 0 writes `(read & ~mask) | value`. Method 1 writes read+1 and method 2 writes read-1, both wrapping modulo 2^32 (0xFFFFFFFF+1 = 0, 0-1 = 0xFFFFFFFF).
- R4: Method 3 writes read>>1 and method 4 writes read<<1, with the vacated bit filled with 0.
- R5: Method 5 rotates right by one, so bit 0 moves to bit 31. Method 6 rotates left by one, so bit 31 moves to bit 0.
- R6: Method 7 writes the bitwise inverse of the read value.
- R7: Method 8 writes read XOR mask, method 9 writes read OR mask, and method 10 writes read AND mask.
- R8: A method code of 11 to 15 causes no read and no write. `done_o` and `err_o` pulse together for one cycle, one cycle after the start edge.
- R9: While an operation is in progress, a further start strobe is ignored. The address, method, value and mask of the running operation are unchanged.
- R10: The unit waits for any number of cycles for `rd_valid_i` and for `wr_ack_i`. No write request comes before read data is accepted. `done_o` pulses for one cycle, one cycle after the acknowledge edge.
- R11: `err_o` is high only together with `done_o`, and it stays low for every legal method.
- R12: Only descriptor bits 11:8 select the method. Every other descriptor bit has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe, sampled only while idle |
| start_addr_i | input | 32 | Target address |
| start_desc_i | input | 32 | Descriptor word; method code in bits 11:8 |
| start_value_i | input | 32 | Write value used by method 0 |
| start_mask_i | input | 32 | Write mask used by methods 0, 8, 9, 10 |
| rd_req_o | output | 1 | Read request pulse |
| rd_addr_o | output | 32 | Read address |
| rd_valid_i | input | 1 | Read data valid |
| rd_data_i | input | 32 | Read data |
| wr_req_o | output | 1 | Write request pulse |
| wr_addr_o | output | 32 | Write address |
| wr_data_o | output | 32 | Write data |
| wr_ack_i | input | 1 | Write acknowledge |
| done_o | output | 1 | Operation complete pulse |
| err_o | output | 1 | Illegal method flag, coincident with done |

## Verification
A sequencer stuck in a wait state shows up as a missing `wr_req_o` or `done_o` at the exact cycle the bench predicts for it. A skipped state shows up as a request or done pulse one cycle early. An operand latch that reloads mid-operation shows up on the next write as a changed `wr_addr_o` or a changed `wr_data_o`. A wrong method decode shows up as a wrong `wr_data_o` on the same write. For an illegal code, the fault appears within one cycle of the start: either a read request appears, or `done_o` and `err_o` do not pulse together.

// File: rtl/rmw_pkg.sv
package rmw_pkg;

    typedef enum logic [3:0] {
        M_INSERT = 4'd0,
        M_INC    = 4'd1,
        M_DEC    = 4'd2,
        M_SHR    = 4'd3,
        M_SHL    = 4'd4,
        M_ROR    = 4'd5,
        M_ROL    = 4'd6,
        M_INV    = 4'd7,
        M_XOR    = 4'd8,
        M_OR     = 4'd9,
        M_AND    = 4'd10
    } rmw_method_e;

    localparam int unsigned METHOD_W    = 4;
    localparam int unsigned METHOD_LAST = 10;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RD_ISSUE,
        S_RD_WAIT,
        S_CALC,
        S_WR_ISSUE,
        S_WR_WAIT,
        S_DONE
    } rmw_state_e;

endpackage

// File: rtl/rmw_alu.sv
module rmw_alu
    import rmw_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input  logic [METHOD_W-1:0] method_i,
    input  logic [DW-1:0]       rd_i,
    input  logic [DW-1:0]       value_i,
    input  logic [DW-1:0]       mask_i,
    output logic [DW-1:0]       res_o
);

    localparam logic [DW-1:0] ONE = {{(DW-1){1'b0}}, 1'b1};

    always_comb begin
        res_o = rd_i;
        case (method_i)
            M_INSERT: res_o = (rd_i & ~mask_i) | value_i;
            M_INC:    res_o = rd_i + ONE;
            M_DEC:    res_o = rd_i - ONE;
            M_SHR:    res_o = {1'b0, rd_i[DW-1:1]};
            M_SHL:    res_o = {rd_i[DW-2:0], 1'b0};
            M_ROR:    res_o = {rd_i[0], rd_i[DW-1:1]};
            M_ROL:    res_o = {rd_i[DW-2:0], rd_i[DW-1]};
            M_INV:    res_o = ~rd_i;
            M_XOR:    res_o = rd_i ^ mask_i;
            M_OR:     res_o = rd_i | mask_i;
            M_AND:    res_o = rd_i & mask_i;
            default:  res_o = rd_i;
        endcase
    end

endmodule

// File: rtl/rmw_seq.sv
module rmw_seq
    import rmw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic illegal_i,
    input  logic rd_valid_i,
    input  logic wr_ack_i,
    output logic busy_o,
    output logic load_o,
    output logic cap_rd_o,
    output logic cap_res_o,
    output logic rd_req_o,
    output logic wr_req_o,
    output logic done_o,
    output logic err_o
);

    rmw_state_e state_q, state_d;
    logic       bad_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:     if (start_i) state_d = illegal_i ? S_DONE : S_RD_ISSUE;
            S_RD_ISSUE: state_d = S_RD_WAIT;
            S_RD_WAIT:  if (rd_valid_i) state_d = S_CALC;
            S_CALC:     state_d = S_WR_ISSUE;
            S_WR_ISSUE: state_d = S_WR_WAIT;
            S_WR_WAIT:  if (wr_ack_i) state_d = S_DONE;
            S_DONE:     state_d = S_IDLE;
            default:    state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            bad_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == S_IDLE && start_i) bad_q <= illegal_i;
        end
    end

    always_comb begin
        busy_o    = 1'b1;
        load_o    = 1'b0;
        cap_rd_o  = 1'b0;
        cap_res_o = 1'b0;
        rd_req_o  = 1'b0;
        wr_req_o  = 1'b0;
        done_o    = 1'b0;
        err_o     = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                busy_o = 1'b0;
                load_o = start_i;
            end
            S_RD_ISSUE: rd_req_o  = 1'b1;
            S_RD_WAIT:  cap_rd_o  = rd_valid_i;
            S_CALC:     cap_res_o = 1'b1;
            S_WR_ISSUE: wr_req_o  = 1'b1;
            S_WR_WAIT:  ;
            S_DONE: begin
                done_o = 1'b1;
                err_o  = bad_q;
            end
            default: ;
        endcase
    end

    AST_RD_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |=> !rd_req_o); // R2
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R10
    AST_ERR_ONLY_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> done_o); // R11
    AST_DONE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !err_o) |-> $past(wr_ack_i)); // R10
    AST_ILLEGAL_FAST_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i && illegal_i) |=> (done_o && err_o)); // R8

endmodule

// File: rtl/rmw_engine.sv
module rmw_engine
    import rmw_pkg::*;
#(
    parameter int unsigned DW       = 32,
    parameter int unsigned AW       = 32,
    parameter int unsigned METH_LSB = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [AW-1:0] start_addr_i,
    input  logic [DW-1:0] start_desc_i,
    input  logic [DW-1:0] start_value_i,
    input  logic [DW-1:0] start_mask_i,
    output logic          rd_req_o,
    output logic [AW-1:0] rd_addr_o,
    input  logic          rd_valid_i,
    input  logic [DW-1:0] rd_data_i,
    output logic          wr_req_o,
    output logic [AW-1:0] wr_addr_o,
    output logic [DW-1:0] wr_data_o,
    input  logic          wr_ack_i,
    output logic          done_o,
    output logic          err_o
);

    localparam int unsigned METH_MSB = METH_LSB + METHOD_W - 1;

    logic [METHOD_W-1:0] start_method;
    logic                start_illegal;
    logic                unused_desc;

    assign start_method  = start_desc_i[METH_MSB:METH_LSB];
    assign start_illegal = (start_method > METHOD_W'(METHOD_LAST));
    assign unused_desc   = ^{start_desc_i[DW-1:METH_MSB+1], start_desc_i[METH_LSB-1:0]};

    logic [AW-1:0]       addr_q;
    logic [METHOD_W-1:0] method_q;
    logic [DW-1:0]       value_q, mask_q, rdata_q, result_q, alu_res;
    logic                busy, load, cap_rd, cap_res;

    rmw_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .illegal_i  (start_illegal),
        .rd_valid_i (rd_valid_i),
        .wr_ack_i   (wr_ack_i),
        .busy_o     (busy),
        .load_o     (load),
        .cap_rd_o   (cap_rd),
        .cap_res_o  (cap_res),
        .rd_req_o   (rd_req_o),
        .wr_req_o   (wr_req_o),
        .done_o     (done_o),
        .err_o      (err_o)
    );

    rmw_alu #(.DW(DW)) u_alu (
        .method_i (method_q),
        .rd_i     (rdata_q),
        .value_i  (value_q),
        .mask_i   (mask_q),
        .res_o    (alu_res)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q   <= '0;
            method_q <= '0;
            value_q  <= '0;
            mask_q   <= '0;
            rdata_q  <= '0;
            result_q <= '0;
        end else begin
            if (load) begin
                addr_q   <= start_addr_i;
                method_q <= start_method;
                value_q  <= start_value_i;
                mask_q   <= start_mask_i;
            end
            if (cap_rd)  rdata_q  <= rd_data_i;
            if (cap_res) result_q <= alu_res;
        end
    end

    assign rd_addr_o = addr_q;
    assign wr_addr_o = addr_q;
    assign wr_data_o = result_q;

    AST_OPERANDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(addr_q) && $stable(method_q) && $stable(mask_q))); // R9
    AST_NO_WRITE_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req_o |-> (method_q <= METHOD_W'(METHOD_LAST))); // R8
    AST_NO_REQ_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req_o && wr_req_o)); // R2

endmodule

// File: tb/rmw_engine_tb.sv
module rmw_engine_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] start_addr_i = '0, start_desc_i = '0, start_value_i = '0, start_mask_i = '0;
    logic        rd_req_o, wr_req_o, done_o, err_o;
    logic [31:0] rd_addr_o, wr_addr_o, wr_data_o;
    logic        rd_valid_i = 1'b0, wr_ack_i = 1'b0;
    logic [31:0] rd_data_i = '0;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    rmw_engine dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .start_addr_i(start_addr_i), .start_desc_i(start_desc_i),
        .start_value_i(start_value_i), .start_mask_i(start_mask_i),
        .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o),
        .rd_valid_i(rd_valid_i), .rd_data_i(rd_data_i),
        .wr_req_o(wr_req_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
        .wr_ack_i(wr_ack_i), .done_o(done_o), .err_o(err_o)
    );

    function automatic logic [31:0] expect_val(input logic [3:0] m, input logic [31:0] r,
                                               input logic [31:0] v, input logic [31:0] k);
        case (m)
            4'd0:  return (r & ~k) | v;
            4'd1:  return r + 32'd1;
            4'd2:  return r - 32'd1;
            4'd3:  return r >> 1;
            4'd4:  return r << 1;
            4'd5:  return {r[0], r[31:1]};
            4'd6:  return {r[30:0], r[31]};
            4'd7:  return ~r;
            4'd8:  return r ^ k;
            4'd9:  return r | k;
            default: return r & k;
        endcase
    endfunction

    function automatic string req_of(input logic [3:0] m);
        if (m <= 4'd2) return "R3";
        if (m <= 4'd4) return "R4";
        if (m <= 4'd6) return "R5";
        if (m == 4'd7) return "R6";
        return "R7";
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp_v);
        n_tests++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp_v);
        end
    endtask

    // legal operation; intrude = issue a stray start while waiting for read data (R9)
    task automatic run_op(input logic [31:0] addr, input logic [31:0] desc, input logic [31:0] val,
                          input logic [31:0] msk, input logic [31:0] rdat,
                          input int rd_lat, input int ack_lat, input bit intrude);
        logic [3:0] m;
        m = desc[11:8];
        @(negedge clk);
        start_i = 1'b1; start_addr_i = addr; start_desc_i = desc;
        start_value_i = val; start_mask_i = msk;
        @(negedge clk);
        start_i = 1'b0;
        check("R2 rd_req", {31'd0, rd_req_o}, 32'd1);
        check("R2 rd_addr", rd_addr_o, addr);
        for (int i = 0; i < rd_lat; i++) begin
            if (intrude && i == 0) begin
                start_i = 1'b1; start_addr_i = ~addr; start_desc_i = 32'h0000_0700;
                start_mask_i = ~msk; start_value_i = ~val;
            end
            @(negedge clk);
            start_i = 1'b0;
            check("R2 rd_req single", {31'd0, rd_req_o}, 32'd0);
            check("R10 no early write", {31'd0, wr_req_o}, 32'd0);
        end
        rd_valid_i = 1'b1; rd_data_i = rdat;
        @(negedge clk);
        rd_valid_i = 1'b0; rd_data_i = 32'hDEAD_BEEF;
        check("R10 no write in calc", {31'd0, wr_req_o}, 32'd0);
        @(negedge clk);
        check("R2 wr_req", {31'd0, wr_req_o}, 32'd1);
        check(intrude ? "R9 wr_addr" : "R2 wr_addr", wr_addr_o, addr);
        check(intrude ? "R9 wr_data" : req_of(m), wr_data_o, expect_val(m, rdat, val, msk));
        for (int i = 0; i < ack_lat; i++) begin
            @(negedge clk);
            check("R2 wr_req single", {31'd0, wr_req_o}, 32'd0);
            check("R10 done waits ack", {31'd0, done_o}, 32'd0);
        end
        wr_ack_i = 1'b1;
        @(negedge clk);
        wr_ack_i = 1'b0;
        check("R10 done", {31'd0, done_o}, 32'd1);
        check("R11 err low on legal", {31'd0, err_o}, 32'd0);
        @(negedge clk);
        check("R10 done one cycle", {31'd0, done_o}, 32'd0);
    endtask

    task automatic run_illegal(input logic [3:0] code);
        @(negedge clk);
        start_i = 1'b1; start_addr_i = 32'h1234_5678; start_desc_i = {20'h0, code, 8'hFF};
        @(negedge clk);
        start_i = 1'b0;
        check("R8 done", {31'd0, done_o}, 32'd1);
        check("R8 err", {31'd0, err_o}, 32'd1);
        check("R8 no read", {31'd0, rd_req_o}, 32'd0);
        @(negedge clk);
        check("R8 pulse ends", {30'd0, done_o, err_o}, 32'd0);
        check("R8 no write", {30'd0, rd_req_o, wr_req_o}, 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R1 reset outputs", {28'd0, rd_req_o, wr_req_o, done_o, err_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", {28'd0, rd_req_o, wr_req_o, done_o, err_o}, 32'd0);

        // directed corners
        run_op(32'h100, 32'h0000_0100, 0, 0, 32'hFFFF_FFFF, 1, 1, 0);       // R3 inc wrap
        run_op(32'h104, 32'h0000_0200, 0, 0, 32'h0000_0000, 2, 1, 0);       // R3 dec wrap
        run_op(32'h108, 32'h0000_0000, 32'h0000_00A0, 32'h0000_00F0, 32'h1234_5678, 1, 2, 0); // R3 insert
        run_op(32'h10C, 32'h0000_0300, 0, 0, 32'h8000_0001, 1, 1, 0);       // R4 shr fill
        run_op(32'h110, 32'h0000_0400, 0, 0, 32'h8000_0001, 1, 1, 0);       // R4 shl fill
        run_op(32'h114, 32'h0000_0500, 0, 0, 32'h0000_0001, 1, 1, 0);       // R5 ror
        run_op(32'h118, 32'h0000_0600, 0, 0, 32'h8000_0000, 1, 1, 0);       // R5 rol
        run_op(32'h11C, 32'h0000_0700, 0, 0, 32'h0F0F_1234, 1, 1, 0);       // R6 invert
        run_op(32'h120, 32'h0000_0800, 0, 32'hFF00_FF00, 32'hF0F0_F0F0, 1, 1, 0); // R7 xor
        run_op(32'h124, 32'h0000_0900, 0, 32'h0000_FFFF, 32'h1200_0034, 1, 1, 0); // R7 or
        run_op(32'h128, 32'h0000_0A00, 0, 32'h0000_FFFF, 32'hABCD_1234, 1, 1, 0); // R7 and
        run_op(32'h12C, 32'hFFFF_F1FF, 0, 0, 32'h0000_0041, 1, 1, 0);       // R12 other bits set, method 1
        run_op(32'h130, 32'h0000_0300, 0, 32'h5555_5555, 32'h0000_0010, 3, 2, 1); // R9 stray start
        run_op(32'h134, 32'h0000_0900, 0, 32'h1, 32'h2, 12, 9, 0);          // R10 long waits
        run_illegal(4'd11);                                                   // R8
        run_illegal(4'd15);                                                   // R8

        for (int n = 0; n < 200; n++) begin
            logic [31:0] d;
            d = $urandom;
            if (d[11:8] > 4'd10) d[11:8] = 4'($urandom_range(0, 10));
            if (n % 25 == 7) run_illegal(4'($urandom_range(11, 15)));
            run_op($urandom, d, $urandom, $urandom, $urandom,
                   $urandom_range(1, 4), $urandom_range(1, 4), (n % 10 == 3));
        end

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule